// File: doc/BRIEF.md
# Output Stream Serializer

The block sits between a datapath that produces a group of results in one cycle and a memory-side consumer that takes one value at a time. When the datapath offers a result set (NUM_ELEM data words and one base address), the block captures it and presents the elements one by one on a single data port. Each element has its own address, which is the base plus the element's position. The consumer takes each element with a valid/pop handshake.

The block back-pressures the datapath while it is serializing, so no new set overwrites elements that are still unsent. When the last element of a set is taken and another set is already offered, the new set is loaded on that same edge, so valid shows no gap. An external stall request is registered and merged into the same back-pressure signal. It never touches the stream handshake. The datapath flags its final set, and the block raises a sticky completion flag once that set has fully drained.

Top module: `ostr_serializer`

## Requirements
- R1: A set is accepted on a rising edge where `set_valid_i` is high and `dp_stall_o` is low. After that edge, `out_valid_o` is high with element 0 and address `set_base_i`.
- R2: While `out_valid_o` is high and `out_pop_i` is low, the data and address outputs hold steady. A pop moves to the next element on the following cycle.
- R3: `dp_stall_o` is high while more than one element of the current set is unsent. It is also high while exactly one is unsent and `out_pop_i` is low.
- R4: Element i is taken from bits `[i*DATA_W +: DATA_W]` of `set_data_i`. Elements go out in order from i = 0 to NUM_ELEM-1, and element i carries address (base + i) modulo 2^ADDR_W.
- R5: `ext_stall_i` raises `dp_stall_o` starting STALL_LAT cycles later (default 1) and releases it with the same delay. Pops and element advances proceed normally while it is high.
- R6: If the final element is popped while a new set is offered and back-pressure is low, the new set loads on that edge and `out_valid_o` stays high with no gap.
- R7: `done_o` rises on the edge that takes the final element of the set accepted with `set_last_i` high. It then stays high until reset.
- R8: Once a set flagged with `set_last_i` has been accepted, `dp_stall_o` stays high and no further set is accepted.
- R9: During reset and right after it, `out_valid_o`, `done_o` and `dp_stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_valid_i | input | 1 | Datapath offers a result set |
| set_data_i | input | NUM_ELEM*DATA_W | Parallel results, element i in slice i |
| set_base_i | input | ADDR_W | Address of element 0 of the offered set |
| set_last_i | input | 1 | Offered set is the final one |
| ext_stall_i | input | 1 | External request to freeze the datapath |
| dp_stall_o | output | 1 | Freeze request to the datapath |
| out_valid_o | output | 1 | An element is presented on the stream |
| out_data_o | output | DATA_W | Presented element |
| out_addr_o | output | ADDR_W | Destination address of the presented element |
| out_pop_i | input | 1 | Consumer takes the presented element |
| done_o | output | 1 | Final set fully drained (sticky) |

## Verification
Set offers, pops and external stall requests are drawn at random from a fixed seed. Each cycle is compared with a queue model that predicts data, address, valid, back-pressure and completion. A slow consumer exercises the holding behaviour. A back-to-back offer timed against the final pop shows whether the bubble-free reload happens or a cycle of valid is lost. A base address near the top of the address range separates a correct modulo increment from a truncated one. External stall pulses during active draining show that the handshake stays independent of the freeze. After the final set, continued offers confirm that completion is sticky and that no further set is accepted.

// File: rtl/ostr_pkg.sv
package ostr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ostr_rst_sync.sv
module ostr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync_o = sync_q;

endmodule

// File: rtl/ostr_stall_sync.sv
module ostr_stall_sync #(
  parameter int STALL_LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_i,
  output logic stall_o
);

  generate
    if (STALL_LAT <= 1) begin : g_one
      logic stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= 1'b0;
        else        stg_q <= stall_i;
      end
      assign stall_o = stg_q;

      AST_STALL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> stall_o);  // R5
      AST_STALL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_i |=> !stall_o);  // R5
    end else begin : g_two
      logic stg0_q;
      logic stg1_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg0_q <= 1'b0;
          stg1_q <= 1'b0;
        end else begin
          stg0_q <= stall_i;
          stg1_q <= stg0_q;
        end
      end
      assign stall_o = stg1_q;
    end
  endgenerate

endmodule

// File: rtl/ostr_elem_buf.sv
module ostr_elem_buf #(
  parameter  int NUM_ELEM = 4,
  parameter  int DATA_W   = 16,
  localparam int IDX_W    = ostr_pkg::idx_width(NUM_ELEM),
  localparam int VEC_W    = NUM_ELEM * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [VEC_W-1:0]  data_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] elem_q [NUM_ELEM];

  generate
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elem
      logic [DATA_W-1:0] elem_d;
      assign elem_d = data_i[g*DATA_W +: DATA_W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      elem_q[g] <= '0;
        else if (load_i) elem_q[g] <= elem_d;
      end
    end
  endgenerate

  always_comb begin
    data_o = elem_q[0];
    for (int i = 0; i < NUM_ELEM; i++) begin
      if (sel_i == IDX_W'(i)) data_o = elem_q[i];
    end
  end

endmodule

// File: rtl/ostr_seq_ctrl.sv
module ostr_seq_ctrl #(
  parameter  int NUM_ELEM = 4,
  parameter  int ADDR_W   = 12,
  localparam int IDX_W    = ostr_pkg::idx_width(NUM_ELEM),
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_ELEM - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              last_i,
  input  logic              pop_i,
  output logic              active_o,
  output logic              last_elem_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              can_load_o,
  output logic              done_o
);

  import ostr_pkg::*;

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic [ADDR_W-1:0] base_q;
  logic              final_set_q;
  logic              set_en;
  logic              fire;
  logic              last_elem;

  assign last_elem = (idx_q == IDX_LAST);
  assign fire      = (state_q == ST_SEND) && pop_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    set_en  = 1'b0;
    if (load_i) begin
      state_d = ST_SEND;
      idx_d   = '0;
      idx_en  = 1'b1;
      set_en  = 1'b1;
    end else if (fire) begin
      if (last_elem) begin
        state_d = final_set_q ? ST_FIN : ST_IDLE;
      end else begin
        idx_d  = idx_q + 1'b1;
        idx_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q      <= '0;
      final_set_q <= 1'b0;
    end else if (set_en) begin
      base_q      <= base_i;
      final_set_q <= last_i;
    end
  end

  assign active_o    = (state_q == ST_SEND);
  assign last_elem_o = last_elem;
  assign idx_o       = idx_q;
  assign addr_o      = base_q + ADDR_W'(idx_q);
  assign done_o      = (state_q == ST_FIN);
  assign can_load_o  = !final_set_q &&
                       ((state_q == ST_IDLE) || (fire && last_elem));

  AST_LOAD_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> can_load_o);  // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);  // R7
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(fire && last_elem && final_set_q));  // R7
  AST_NO_SET_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    final_set_q |=> final_set_q);  // R8

endmodule

// File: rtl/ostr_serializer.sv
module ostr_serializer #(
  parameter  int NUM_ELEM  = 4,
  parameter  int DATA_W    = 16,
  parameter  int ADDR_W    = 12,
  parameter  int STALL_LAT = 1,
  localparam int IDX_W     = ostr_pkg::idx_width(NUM_ELEM),
  localparam int VEC_W     = NUM_ELEM * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid_i,
  input  logic [VEC_W-1:0]  set_data_i,
  input  logic [ADDR_W-1:0] set_base_i,
  input  logic              set_last_i,
  input  logic              ext_stall_i,
  output logic              dp_stall_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [ADDR_W-1:0] out_addr_o,
  input  logic              out_pop_i,
  output logic              done_o
);

  logic             rst_n_s;
  logic             stall_eff;
  logic             can_load;
  logic             load;
  logic             active;
  logic             last_elem;
  logic [IDX_W-1:0] idx;

  ostr_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  ostr_stall_sync #(
    .STALL_LAT (STALL_LAT)
  ) u_stall_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .stall_i (ext_stall_i),
    .stall_o (stall_eff)
  );

  assign dp_stall_o = !can_load || stall_eff;
  assign load       = set_valid_i && !dp_stall_o;

  ostr_seq_ctrl #(
    .NUM_ELEM (NUM_ELEM),
    .ADDR_W   (ADDR_W)
  ) u_seq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .load_i      (load),
    .base_i      (set_base_i),
    .last_i      (set_last_i),
    .pop_i       (out_pop_i),
    .active_o    (active),
    .last_elem_o (last_elem),
    .idx_o       (idx),
    .addr_o      (out_addr_o),
    .can_load_o  (can_load),
    .done_o      (done_o)
  );

  ostr_elem_buf #(
    .NUM_ELEM (NUM_ELEM),
    .DATA_W   (DATA_W)
  ) u_elem_buf (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (load),
    .data_i (set_data_i),
    .sel_i  (idx),
    .data_o (out_data_o)
  );

  assign out_valid_o = active;

  AST_HOLD_ELEM: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid_o && !out_pop_i |=> out_valid_o && $stable(out_data_o) && $stable(out_addr_o));  // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid_o && out_pop_i && !last_elem |=> out_valid_o && (out_addr_o == $past(out_addr_o) + 1'b1));  // R4
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid_o && out_pop_i && set_valid_i && !dp_stall_o |=> out_valid_o && (idx == '0));  // R6
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid_o && !last_elem |-> dp_stall_o);  // R3
  AST_FINAL_STALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> dp_stall_o && !out_valid_o);  // R8

endmodule

// File: tb/ostr_serializer_bench.sv
module ostr_serializer_bench;

  localparam int CLK_P  = 10;
  localparam int K      = 4;
  localparam int DW     = 16;
  localparam int AW     = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              set_valid;
  logic [K*DW-1:0]   set_data;
  logic [AW-1:0]     set_base;
  logic              set_last;
  logic              ext_stall;
  logic              dp_stall;
  logic              out_valid;
  logic [DW-1:0]     out_data;
  logic [AW-1:0]     out_addr;
  logic              out_pop;
  logic              done;

  int checks = 0;
  int errors = 0;
  int reload_seen = 0;
  bit finished = 1'b0;

  logic [DW-1:0] q_data [$];
  logic [AW-1:0] q_addr [$];
  bit            stall_d = 1'b0;
  bit            last_acc = 1'b0;
  bit            done_exp = 1'b0;
  bit            pend = 1'b0;
  logic [K*DW-1:0] pend_data = '0;
  logic [AW-1:0]   pend_base = '0;
  bit              pend_last = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ostr_serializer #(
    .NUM_ELEM (K),
    .DATA_W   (DW),
    .ADDR_W   (AW)
  ) u_ostr_serializer (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_valid_i (set_valid),
    .set_data_i  (set_data),
    .set_base_i  (set_base),
    .set_last_i  (set_last),
    .ext_stall_i (ext_stall),
    .dp_stall_o  (dp_stall),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .out_addr_o  (out_addr),
    .out_pop_i   (out_pop),
    .done_o      (done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] slice_of(input logic [K*DW-1:0] v, input int i);
    return v[i*DW +: DW];
  endfunction

  function automatic bit stall_expect(input int pending, input bit pop);
    return stall_d || last_acc || (pending > 1) || (pending == 1 && !pop);
  endfunction

  // One cycle: drive at the falling edge, check, update the model for the next rising edge.
  task automatic step(input bit sv, input bit lst, input bit pop, input bit st,
                      input logic [AW-1:0] base, input logic [K*DW-1:0] data);
    bit accepted;
    bit popped;
    @(negedge clk);
    if (!pend && sv) begin
      pend      = 1'b1;
      pend_data = data;
      pend_base = base;
      pend_last = lst;
    end
    set_valid = pend;
    set_data  = pend_data;
    set_base  = pend_base;
    set_last  = pend_last;
    out_pop   = pop;
    ext_stall = st;
    #1;
    check(dp_stall == stall_expect(q_data.size(), pop), "R3 R5 R8 dp_stall",
          dp_stall, stall_expect(q_data.size(), pop));
    check(out_valid == (q_data.size() != 0), "R1 R2 R6 out_valid",
          out_valid, q_data.size() != 0);
    if (q_data.size() != 0) begin
      check(out_data == q_data[0], "R4 out_data", out_data, q_data[0]);
      check(out_addr == q_addr[0], "R4 out_addr", out_addr, q_addr[0]);
    end
    check(done == done_exp, "R7 done", done, done_exp);
    accepted = pend && !dp_stall;
    popped   = out_valid && pop;
    if (popped && q_data.size() != 0) begin
      void'(q_data.pop_front());
      void'(q_addr.pop_front());
      if (accepted && q_data.size() == 0) reload_seen++;
    end
    if (accepted) begin
      for (int i = 0; i < K; i++) begin
        q_data.push_back(slice_of(pend_data, i));
        q_addr.push_back(pend_base + AW'(i));
      end
      if (pend_last) last_acc = 1'b1;
      pend = 1'b0;
    end
    if (popped && q_data.size() == 0 && last_acc) done_exp = 1'b1;
    stall_d = st;
  endtask

  function automatic logic [K*DW-1:0] rnd_vec();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; set_valid = 1'b0; set_data = '0; set_base = '0;
    set_last = 1'b0; ext_stall = 1'b0; out_pop = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !done && !dp_stall, "R9 in reset", {out_valid, done, dp_stall}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !done && !dp_stall, "R9 after reset", {out_valid, done, dp_stall}, 0);

    // R1 R4: a set near the top of the address range, with a slow consumer (R2)
    step(1, 0, 0, 0, 12'hFFE, 64'h4444_3333_2222_1111);
    repeat (3) step(0, 0, 0, 0, '0, '0);
    for (int i = 0; i < K; i++) begin
      step(0, 0, 1, 0, '0, '0);
      step(0, 0, 0, 0, '0, '0);
    end

    // R6: new set waits while the current one drains, reload on the final pop
    step(1, 0, 0, 0, 12'h100, 64'hAAAA_BBBB_CCCC_DDDD);
    step(1, 0, 1, 0, 12'h200, 64'h0102_0304_0506_0708);
    repeat (K + 1) step(0, 0, 1, 0, '0, '0);
    check(reload_seen >= 1, "R6 reload on final pop", reload_seen, 1);

    // R5: external stall while idle blocks acceptance, then during draining pops still move
    step(0, 0, 0, 1, '0, '0);
    step(1, 0, 0, 1, 12'h300, rnd_vec());
    step(0, 0, 0, 0, '0, '0);
    step(0, 0, 0, 1, '0, '0);
    repeat (K) step(0, 0, 1, 1, '0, '0);
    step(0, 0, 0, 0, '0, '0);

    // Random traffic
    for (int c = 0; c < 600; c++) begin
      step(($urandom() % 3) != 0, 0, ($urandom() % 5) < 3, ($urandom() % 6) == 0,
           AW'($urandom()), rnd_vec());
    end
    while (q_data.size() != 0 || pend) step(0, 0, 1, 0, '0, '0);

    // R7 R8: final set, drain, then continued offers must be refused
    step(1, 1, 0, 0, 12'h7F0, rnd_vec());
    repeat (2 * K) step(0, 0, 1, 0, '0, '0);
    check(done_exp, "R7 model reached done", done_exp, 1);
    repeat (6) step(1, 0, $urandom() % 2, 0, 12'h055, rnd_vec());
    #1;
    check(done && dp_stall && !out_valid, "R7 R8 final state",
          {done, dp_stall, out_valid}, 3'b110);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule